// File: doc/BRIEF.md
# CD Sector Byte-to-Word Host Port

This block takes the byte stream coming out of a CD data controller and packs it into a 16-bit word that a processor collects by polling. Bytes arrive on a valid/ready handshake. Two consecutive accepted bytes form one word: the earlier byte goes in the upper half and the later byte in the lower half. After the second byte the block raises a data-ready flag. The byte source is then held off until the word has been taken.

A 3-bit routing field in a small control register names the processor that owns the port. Only a read strobe from that processor returns the word and frees the port. A read from the other processor returns all ones and has no side effect. The control register also carries a transfer-done flag, which is set when the byte marked as last in the transfer is accepted. When the routing field names neither processor, incoming bytes are accepted and dropped.

Top module: `cdc_host_port`

## Requirements
- R1: After reset the data-ready flag, the transfer-done flag and the routing field all read 0, the pair phase is "upper byte next", and the held word is 0x0000.
- R2: `ctrl_rdata` shows the routing field in bits 10:8, the data-ready flag in bit 14 and the transfer-done flag in bit 15, with all other bits 0. Code 2 selects the main processor and code 3 selects the sub processor.
- R3: The first byte of a pair is stored in bits 15:8 of the held word and the second byte in bits 7:0.
- R4: Accepting the second byte of a pair while a processor is selected sets the data-ready flag, and it reads as 1 in the cycle after that byte is accepted.
- R5: While the data-ready flag is set, `byte_ready` is low, no byte is accepted and the held word does not change.
- R6: A read strobe from the selected processor returns the held word on that processor's data output. It also clears the data-ready flag, so `byte_ready` is high again in the next cycle.
- R7: A read from a processor that is not selected returns 0xFFFF and leaves both flags and the held word unchanged.
- R8: Accepting a byte with `byte_last` high sets the transfer-done flag. A write to the control register clears it.
- R9: A control-register write that changes the routing field returns the pair phase to "upper byte next".
- R10: When the routing field is neither 2 nor 3, bytes are accepted, the held word and the data-ready flag stay unchanged, and the pair phase does not advance.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| byte_valid | input | 1 | Byte source has a byte |
| byte_data | input | 8 | Byte from the controller |
| byte_last | input | 1 | This byte ends the transfer |
| byte_ready | output | 1 | Port can take a byte this cycle |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 16 | Control write data; bits 10:8 are the routing field |
| ctrl_rdata | output | 16 | Control register read value |
| rd_main | input | 1 | Main processor reads the data word |
| rd_sub | input | 1 | Sub processor reads the data word |
| main_rdata | output | 16 | Data word as seen by the main processor |
| sub_rdata | output | 16 | Data word as seen by the sub processor |

## Verification
The hardest case to reach from the ports is a routing change that arrives between the two bytes of a pair. Only the phase reset can keep the next byte out of the wrong half of the word. A second hard case is a stalled source that must resume on the very next cycle after the owning processor reads. The random stimulus mixes byte pushes, reads from both processors and control writes with routing codes 2, 3 and 5. This lands routing changes at every pair phase and with the port both full and empty. Directed sequences then cover the last-byte flag, a read from the wrong processor while the port is full, and a mid-pair switch.

// File: rtl/cdc_hp_pkg.sv
package cdc_hp_pkg;
   localparam int unsigned CTRL_W      = 16;
   localparam int unsigned ROUTE_LSB   = 8;
   localparam int unsigned ROUTE_W     = 3;
   localparam int unsigned READY_BIT   = 14;
   localparam int unsigned DONE_BIT    = 15;
   localparam logic [ROUTE_W-1:0] ROUTE_MAIN = 3'd2;
   localparam logic [ROUTE_W-1:0] ROUTE_SUB  = 3'd3;

   typedef enum logic {
      PH_UPPER = 1'b0,
      PH_LOWER = 1'b1
   } pair_phase_e;
endpackage

// File: rtl/cdc_hp_route_dec.sv
module cdc_hp_route_dec
   import cdc_hp_pkg::*;
#(
   parameter logic [ROUTE_W-1:0] MAIN_CODE = ROUTE_MAIN,
   parameter logic [ROUTE_W-1:0] SUB_CODE  = ROUTE_SUB
) (
   input  logic [ROUTE_W-1:0] route,
   input  logic               rd_main,
   input  logic               rd_sub,
   output logic               main_sel,
   output logic               sub_sel,
   output logic               host_sel,
   output logic               own_rd
);
   initial begin
      if (MAIN_CODE == SUB_CODE)
         $error("cdc_hp_route_dec: processor codes must differ");
   end

   always_comb begin
      main_sel = (route == MAIN_CODE);
      sub_sel  = (route == SUB_CODE);
      host_sel = main_sel | sub_sel;
      own_rd   = (main_sel & rd_main) | (sub_sel & rd_sub);
   end
endmodule

// File: rtl/cdc_hp_packer.sv
module cdc_hp_packer
   import cdc_hp_pkg::*;
#(
   parameter int unsigned BYTE_W = 8,
   parameter int unsigned LANES  = 2
) (
   input  logic                    clk,
   input  logic                    rst_n,
   input  logic                    take,
   input  logic [BYTE_W-1:0]       din,
   input  logic                    phase_clr,
   input  logic                    drain,
   output logic [BYTE_W*LANES-1:0] word_q,
   output logic                    full_q,
   output logic                    ready
);
   localparam int unsigned WORD_W = BYTE_W * LANES;

   initial begin
      if (LANES != 2) $error("cdc_hp_packer: only two lanes are supported");
      if (BYTE_W == 0) $error("cdc_hp_packer: BYTE_W must be nonzero");
   end

   pair_phase_e phase_q;
   logic        fill_done;

   assign ready     = ~full_q;
   assign fill_done = take & (phase_q == PH_LOWER);

   // lane LANES-1 is the upper byte, written first
   for (genvar g = 0; g < LANES; g++) begin : g_lane
      localparam pair_phase_e LANE_PH = (g == LANES - 1) ? PH_UPPER : PH_LOWER;
      always_ff @(posedge clk) begin
         if (!rst_n)
            word_q[g*BYTE_W +: BYTE_W] <= '0;
         else if (take && phase_q == LANE_PH)
            word_q[g*BYTE_W +: BYTE_W] <= din;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         phase_q <= PH_UPPER;
         full_q  <= 1'b0;
      end else begin
         if (phase_clr)
            phase_q <= PH_UPPER;
         else if (take)
            phase_q <= (phase_q == PH_UPPER) ? PH_LOWER : PH_UPPER;
         if (fill_done)
            full_q <= 1'b1;
         else if (drain)
            full_q <= 1'b0;
      end
   end

   a_r5_word_held: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |=> $stable(word_q));
   a_r4_full_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(full_q) |-> $past(take && phase_q == PH_LOWER));
   a_r6_drain_empties: assert property (@(posedge clk) disable iff (!rst_n)
      (full_q && drain) |=> !full_q);
   a_r5_no_take_full: assert property (@(posedge clk) disable iff (!rst_n)
      full_q |-> !take);
endmodule

// File: rtl/cdc_host_port.sv
module cdc_host_port
   import cdc_hp_pkg::*;
#(
   parameter int unsigned BYTE_W = 8
) (
   input  logic                clk,
   input  logic                rst_n,
   input  logic                byte_valid,
   input  logic [BYTE_W-1:0]   byte_data,
   input  logic                byte_last,
   output logic                byte_ready,
   input  logic                ctrl_wr,
   input  logic [CTRL_W-1:0]   ctrl_wdata,
   output logic [CTRL_W-1:0]   ctrl_rdata,
   input  logic                rd_main,
   input  logic                rd_sub,
   output logic [2*BYTE_W-1:0] main_rdata,
   output logic [2*BYTE_W-1:0] sub_rdata
);
   localparam int unsigned WORD_W = 2 * BYTE_W;

   initial begin
      if (WORD_W != CTRL_W) $error("cdc_host_port: word width must match control width");
   end

   logic [ROUTE_W-1:0] route_q;
   logic               done_q;
   logic               main_sel, sub_sel, host_sel, own_rd;
   logic               accepted, take, route_chg;
   logic [WORD_W-1:0]  word_q;
   logic               full_q;

   cdc_hp_route_dec u_dec (
      .route    (route_q),
      .rd_main  (rd_main),
      .rd_sub   (rd_sub),
      .main_sel (main_sel),
      .sub_sel  (sub_sel),
      .host_sel (host_sel),
      .own_rd   (own_rd)
   );

   assign accepted  = byte_valid & byte_ready;
   assign take      = accepted & host_sel;
   assign route_chg = ctrl_wr & (ctrl_wdata[ROUTE_LSB +: ROUTE_W] != route_q);

   cdc_hp_packer #(.BYTE_W(BYTE_W), .LANES(2)) u_pack (
      .clk       (clk),
      .rst_n     (rst_n),
      .take      (take),
      .din       (byte_data),
      .phase_clr (route_chg),
      .drain     (own_rd),
      .word_q    (word_q),
      .full_q    (full_q),
      .ready     (byte_ready)
   );

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         route_q <= '0;
         done_q  <= 1'b0;
      end else begin
         if (ctrl_wr) route_q <= ctrl_wdata[ROUTE_LSB +: ROUTE_W];
         if (accepted && byte_last) done_q <= 1'b1;
         else if (ctrl_wr)          done_q <= 1'b0;
      end
   end

   always_comb begin
      ctrl_rdata = '0;
      ctrl_rdata[ROUTE_LSB +: ROUTE_W] = route_q;
      ctrl_rdata[READY_BIT] = full_q;
      ctrl_rdata[DONE_BIT]  = done_q;
      main_rdata = main_sel ? word_q : '1;
      sub_rdata  = sub_sel  ? word_q : '1;
   end

   a_r8_last_sets_done: assert property (@(posedge clk) disable iff (!rst_n)
      (accepted && byte_last) |=> ctrl_rdata[DONE_BIT]);
   a_r7_foreign_read_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_main && !main_sel && !own_rd && !take && !ctrl_wr) |=> $stable(ctrl_rdata));
   a_r10_drop_no_fill: assert property (@(posedge clk) disable iff (!rst_n)
      (!host_sel && !ctrl_wr) |=> $stable(word_q));
endmodule

// File: tb/tb_cdc_host_port.sv
`timescale 1ns/1ps
module tb_cdc_host_port;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        byte_valid = 1'b0;
   logic [7:0]  byte_data = '0;
   logic        byte_last = 1'b0;
   logic        byte_ready;
   logic        ctrl_wr = 1'b0;
   logic [15:0] ctrl_wdata = '0;
   logic [15:0] ctrl_rdata;
   logic        rd_main = 1'b0;
   logic        rd_sub = 1'b0;
   logic [15:0] main_rdata, sub_rdata;

   int checks = 0;
   int fails  = 0;

   // bench model
   logic [2:0]  m_route = '0;
   logic        m_phase = 1'b0;
   logic [15:0] m_word = '0;
   logic        m_full = 1'b0, m_done = 1'b0;

   always #10 clk = ~clk;

   cdc_host_port dut (.*);

   function automatic logic [15:0] exp_ctrl();
      return {m_done, m_full, 3'b000, m_route, 8'h00};
   endfunction

   function automatic logic [15:0] exp_read(input logic main);
      logic sel = main ? (m_route == 3'd2) : (m_route == 3'd3);
      return sel ? m_word : 16'hFFFF;
   endfunction

   task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
      checks++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic push(input logic [7:0] b, input logic last);
      @(negedge clk);
      chk("R5 ready", {15'd0, byte_ready}, {15'd0, ~m_full});
      if (m_full) return;
      byte_valid = 1'b1; byte_data = b; byte_last = last;
      @(posedge clk); #1;
      byte_valid = 1'b0; byte_last = 1'b0;
      if (m_route == 3'd2 || m_route == 3'd3) begin
         if (!m_phase) m_word[15:8] = b;
         else begin m_word[7:0] = b; m_full = 1'b1; end
         m_phase = ~m_phase;
      end
      if (last) m_done = 1'b1;
      chk("R3 R4 R10 ctrl", ctrl_rdata, exp_ctrl());
   endtask

   task automatic rd(input logic main);
      logic own;
      @(negedge clk);
      own = main ? (m_route == 3'd2) : (m_route == 3'd3);
      rd_main = main; rd_sub = ~main;
      #1;
      chk(own ? "R6 owner read" : "R7 foreign read",
          main ? main_rdata : sub_rdata, exp_read(main));
      @(posedge clk); #1;
      rd_main = 1'b0; rd_sub = 1'b0;
      if (own) m_full = 1'b0;
      chk("R6 R7 flags", ctrl_rdata, exp_ctrl());
      chk("R6 ready", {15'd0, byte_ready}, {15'd0, ~m_full});
   endtask

   task automatic wctl(input logic [2:0] r);
      @(negedge clk);
      ctrl_wr = 1'b1; ctrl_wdata = {5'b10101, r, 8'hA5};
      @(posedge clk); #1;
      ctrl_wr = 1'b0;
      if (r != m_route) m_phase = 1'b0;
      m_route = r; m_done = 1'b0;
      chk("R2 R8 R9 ctrl", ctrl_rdata, exp_ctrl());
   endtask

   initial begin : watchdog
      repeat (100000) @(posedge clk);
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin : main_seq
      int seed;
      seed = 32'h1d3c;
      void'($urandom(seed));
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // R1 reset state
      chk("R1 ctrl", ctrl_rdata, 16'h0000);
      chk("R1 ready", {15'd0, byte_ready}, 16'd1);
      wctl(3'd2);
      rd(1'b1); // R1 word zero
      // R3 R4 pair to main
      push(8'h12, 1'b0);
      push(8'h34, 1'b0);
      // R5 stalled, R7 foreign read while full
      push(8'h99, 1'b0);
      rd(1'b0);
      rd(1'b1);
      // R9 mid-pair route change
      push(8'hAB, 1'b0);
      wctl(3'd3);
      push(8'hCD, 1'b0);
      push(8'hEF, 1'b1); // R8 last
      rd(1'b1);
      rd(1'b0);
      // R10 drop route
      wctl(3'd5);
      push(8'h55, 1'b0);
      push(8'h66, 1'b1);
      rd(1'b1); rd(1'b0);
      // R8 clear by write
      wctl(3'd2);
      // random mix
      for (int i = 0; i < 400; i++) begin
         int unsigned k;
         k = $urandom_range(0, 9);
         if (k < 5) push(8'($urandom), ($urandom_range(0, 15) == 0));
         else if (k < 8) rd(k[0]);
         else begin
            int unsigned c;
            c = $urandom_range(0, 2);
            wctl(c == 0 ? 3'd2 : (c == 1 ? 3'd3 : 3'd5));
         end
      end
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule